// File: doc/BRIEF.md
# Multichannel ADC Sampling Controller

This block sits between a 32-bit register bus and an abstract analog-to-digital converter that serves sixteen input channels. Software asks for one sample on a channel by clearing that channel's bit in the trigger register and then setting it again. The controller detects the 0-to-1 change and holds the request. It hands requests to the converter one at a time through a start/done handshake. When a conversion finishes, it stores the 12-bit result in the channel's data register together with a ready flag.

A global status bit shows whether the converter is working. A power-enable bit must be 1 for any request to be accepted. Clearing a trigger bit invalidates that channel's old result, so software can see the flag drop before it re-arms the channel. Bus reads are combinational. Bus writes take effect at the clock edge that samples them.

Top module: `adcs_ctrl`

## Requirements
- R1: After reset, every register reads 0 and no start pulse is issued.
- R2: A write to the trigger register (offset 0x04, channel n at bit n, bits 15:0) that takes bit n from 0 to 1 while power is enabled queues exactly one conversion for channel n. Writing 1 to a bit that is already 1 queues nothing.
- R3: A write that takes trigger bit n from 1 to 0 sets channel n's ready flag to 0 at that edge. The 12-bit data field keeps its value. A queued request for channel n that has not started yet is dropped.
- R4: Queued requests are served one at a time, lowest channel index first. `conv_start` is a one-cycle pulse carrying the channel index in `conv_chan`. No new start is issued until the current conversion's `conv_done` has been received.
- R5: Bit 0 of the status register (offset 0x10) reads 1 from the edge that raises `conv_start` until the edge that samples `conv_done`, and reads 0 otherwise.
- R6: When `conv_done` is sampled, the data register of the converting channel (offset 0x14 + 4·n) takes `conv_data` in bits 11:0 and sets its ready flag in bit 12.
- R7: The power enable is bit 14 of the register at offset 0x94. A 0-to-1 trigger change while it is 0 is discarded: nothing starts, even after power is later enabled, and the ready flag stays 0. Clearing it drops every queued request, while a conversion already started still completes.
- R8: Unused bits and unmapped or misaligned addresses read 0. Writes to the status and data registers change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_chan | output | 4 | Channel to convert, valid while `conv_start` is high |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_data | input | 12 | Conversion result, valid with `conv_done` |

## Verification
A lost or stale pending bit shows at the ports as a missing or extra `conv_start`, or as starts in the wrong order, within a few cycles of a trigger write. A wrong sequencer state shows at once in the status bit, or as a start issued while a conversion is still outstanding. A wrong result-bank entry shows on the next read of that channel's data register as a wrong value or a wrong ready flag. The random passes re-arm random channel sets and compare every data register against the value the converter model returned for that rank in ascending order. They therefore catch ordering and storage faults on the first pass in which they occur.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
    localparam int unsigned NCH_DEF = 16;
    localparam int unsigned DW_DEF  = 12;
    localparam int unsigned AW_DEF  = 8;
    localparam int unsigned BUS_W   = 32;

    localparam logic [7:0] OFS_TRIG  = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h10;
    localparam logic [7:0] OFS_DATA0 = 8'h14;
    localparam logic [7:0] OFS_PWR   = 8'h94;

    localparam int unsigned PWR_BIT = 14;
    localparam int unsigned RDY_BIT = 12;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adcs_trig_latch.sv
module adcs_trig_latch #(
    parameter int unsigned NCH = adcs_pkg::NCH_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [NCH-1:0] wr_val,
    input  logic           pwr_on,
    input  logic [NCH-1:0] take,
    output logic [NCH-1:0] trig_q,
    output logic [NCH-1:0] pend_q,
    output logic [NCH-1:0] fall
);
    logic [NCH-1:0] rise;

    always_comb begin
        rise = wr_en ? (wr_val & ~trig_q) : '0;
        fall = wr_en ? (~wr_val & trig_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            pend_q <= '0;
        end else begin
            if (wr_en)
                trig_q <= wr_val;
            if (!pwr_on)
                pend_q <= '0;
            else
                pend_q <= (pend_q & ~take & ~fall) | rise;
        end
    end
endmodule

// File: rtl/adcs_prio_pick.sv
module adcs_prio_pick #(
    parameter int unsigned NCH = adcs_pkg::NCH_DEF,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] vec,
    output logic           valid,
    output logic [CW-1:0]  idx
);
    always_comb begin
        valid = |vec;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (vec[i])
                idx = CW'(i);
        end
    end
endmodule

// File: rtl/adcs_conv_seq.sv
module adcs_conv_seq #(
    parameter int unsigned NCH = adcs_pkg::NCH_DEF,
    parameter int unsigned DW  = adcs_pkg::DW_DEF,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pwr_on,
    input  logic           req_valid,
    input  logic [CW-1:0]  req_idx,
    input  logic           conv_done,
    input  logic [DW-1:0]  conv_data,
    output logic           conv_start,
    output logic [CW-1:0]  conv_chan,
    output logic           busy,
    output logic [NCH-1:0] take,
    output logic           res_we,
    output logic [CW-1:0]  res_idx,
    output logic [DW-1:0]  res_data
);
    import adcs_pkg::*;

    seq_state_e    state_q;
    logic [CW-1:0] chan_q;
    logic          start_q;
    logic          launch;

    always_comb begin
        launch   = (state_q == SEQ_IDLE) && pwr_on && req_valid;
        take     = launch ? (NCH'(1) << req_idx) : '0;
        res_we   = (state_q == SEQ_WAIT) && conv_done;
        res_idx  = chan_q;
        res_data = conv_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            chan_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= launch;
            if (launch) begin
                state_q <= SEQ_WAIT;
                chan_q  <= req_idx;
            end else if (res_we) begin
                state_q <= SEQ_IDLE;
            end
        end
    end

    assign conv_start = start_q;
    assign conv_chan  = chan_q;
    assign busy       = (state_q == SEQ_WAIT);
endmodule

// File: rtl/adcs_result_bank.sv
module adcs_result_bank #(
    parameter int unsigned NCH = adcs_pkg::NCH_DEF,
    parameter int unsigned DW  = adcs_pkg::DW_DEF,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    fall,
    input  logic              res_we,
    input  logic [CW-1:0]     res_idx,
    input  logic [DW-1:0]     res_data,
    output logic [NCH*DW-1:0] data_flat,
    output logic [NCH-1:0]    rdy
);
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic          hit;
        logic [DW-1:0] val_q;
        logic          rdy_q;

        assign hit = res_we && (res_idx == CW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
                rdy_q <= 1'b0;
            end else begin
                if (hit)
                    val_q <= res_data;
                if (fall[g])
                    rdy_q <= 1'b0;
                else if (hit)
                    rdy_q <= 1'b1;
            end
        end

        assign data_flat[g*DW +: DW] = val_q;
        assign rdy[g]                = rdy_q;
    end
endmodule

// File: rtl/adcs_ctrl.sv
module adcs_ctrl #(
    parameter int unsigned NCH = adcs_pkg::NCH_DEF,
    parameter int unsigned DW  = adcs_pkg::DW_DEF,
    parameter int unsigned AW  = adcs_pkg::AW_DEF,
    localparam int unsigned CW = $clog2(NCH),
    localparam int unsigned BW = adcs_pkg::BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    output logic          conv_start,
    output logic [CW-1:0] conv_chan,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_data
);
    import adcs_pkg::*;

    logic              pwr_q;
    logic              wr_trig;
    logic [NCH-1:0]    trig_q, pend_q, fall, take, rdy_vec;
    logic              req_valid, seq_busy, res_we;
    logic [CW-1:0]     req_idx, res_idx;
    logic [DW-1:0]     res_data;
    logic [NCH*DW-1:0] data_flat;
    int                data_off;
    int                sel;

    assign wr_trig = bus_we && (bus_addr == AW'(OFS_TRIG));

    always_ff @(posedge clk) begin
        if (rst)
            pwr_q <= 1'b0;
        else if (bus_we && (bus_addr == AW'(OFS_PWR)))
            pwr_q <= bus_wdata[PWR_BIT];
    end

    adcs_trig_latch #(.NCH(NCH)) u_trig (
        .clk(clk), .rst(rst), .wr_en(wr_trig), .wr_val(bus_wdata[NCH-1:0]),
        .pwr_on(pwr_q), .take(take), .trig_q(trig_q), .pend_q(pend_q), .fall(fall)
    );

    adcs_prio_pick #(.NCH(NCH)) u_pick (
        .vec(pend_q), .valid(req_valid), .idx(req_idx)
    );

    adcs_conv_seq #(.NCH(NCH), .DW(DW)) u_seq (
        .clk(clk), .rst(rst), .pwr_on(pwr_q), .req_valid(req_valid), .req_idx(req_idx),
        .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
        .conv_chan(conv_chan), .busy(seq_busy), .take(take), .res_we(res_we),
        .res_idx(res_idx), .res_data(res_data)
    );

    adcs_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk(clk), .rst(rst), .fall(fall), .res_we(res_we), .res_idx(res_idx),
        .res_data(res_data), .data_flat(data_flat), .rdy(rdy_vec)
    );

    always_comb begin
        bus_rdata = '0;
        data_off  = int'(bus_addr) - int'(OFS_DATA0);
        sel       = data_off >>> 2;
        if (bus_addr == AW'(OFS_TRIG))
            bus_rdata[NCH-1:0] = trig_q;
        else if (bus_addr == AW'(OFS_STAT))
            bus_rdata[0] = seq_busy;
        else if (bus_addr == AW'(OFS_PWR))
            bus_rdata[PWR_BIT] = pwr_q;
        else if (data_off >= 0 && data_off < 4 * int'(NCH) && bus_addr[1:0] == 2'b00) begin
            bus_rdata[DW-1:0]  = data_flat[sel*DW +: DW];
            bus_rdata[RDY_BIT] = rdy_vec[sel];
        end
    end
endmodule

// File: rtl/adcs_ctrl_chk.sv
module adcs_ctrl_chk #(
    parameter int unsigned NCH = adcs_pkg::NCH_DEF,
    localparam int unsigned CW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst,
    input logic           conv_start,
    input logic           conv_done,
    input logic [CW-1:0]  chan,
    input logic           busy,
    input logic           pwr_on,
    input logic [NCH-1:0] trig,
    input logic [NCH-1:0] rdy
);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
    // R4
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !$past(busy));
    // R7
    start_power_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(pwr_on));
    // R5
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // R3
        ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(trig[g]) |-> !rdy[g]);
        // R6
        ready_set_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(rdy[g]) |-> $past(conv_done && busy && (chan == CW'(g))));
    end
endmodule

bind adcs_ctrl adcs_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
    .chan(conv_chan), .busy(seq_busy), .pwr_on(pwr_q), .trig(trig_q), .rdy(rdy_vec)
);

// File: tb/adcs_ctrl_test.sv
`timescale 1ns/1ps
module adcs_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;

    int n_chk = 0;
    int n_err = 0;
    int seq_n = 0;
    int lat_cnt = 0;
    logic [3:0] cur_ch = '0;
    int start_log[$];

    always #2.5 clk = ~clk;

    adcs_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data)
    );

    function automatic logic [11:0] conv_val(int ch, int n);
        return {4'(ch), 8'(n)};
    endfunction

    // converter model
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (rst) begin
            lat_cnt <= 0;
        end else if (conv_start) begin
            cur_ch  <= conv_chan;
            lat_cnt <= 1 + int'($urandom % 5);
            start_log.push_back(int'(conv_chan));
        end else if (lat_cnt > 0) begin
            if (lat_cnt == 1) begin
                conv_done <= 1'b1;
                conv_data <= conv_val(int'(cur_ch), seq_n);
                seq_n     <= seq_n + 1;
            end
            lat_cnt <= lat_cnt - 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_convs(int target);
        for (int k = 0; k < 500 && seq_n < target; k++) @(negedge clk);
        idle(2);
    endtask

    function automatic logic [7:0] dreg(int ch);
        return 8'(8'h14 + 4 * ch);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        void'($urandom(32'd7321));
        idle(4);
        rst = 1'b0;

        // R1 reset values
        rd(8'h04, v); chk("R1 trig", v, 0);
        rd(8'h10, v); chk("R1 stat", v, 0);
        rd(8'h94, v); chk("R1 pwr", v, 0);
        rd(8'h14, v); chk("R1 data0", v, 0);
        rd(dreg(15), v); chk("R1 data15", v, 0);

        // R7 trigger while power off is discarded; R8 upper trigger bits read 0
        wr(8'h04, 32'hFFFF_0008);
        idle(15);
        chk("R7 no start", start_log.size(), 0);
        rd(dreg(3), v); chk("R7 ready stays 0", v, 0);
        rd(8'h04, v); chk("R8 trig unused bits", v, 32'h8);
        wr(8'h94, 32'hFFFF_FFFF);
        rd(8'h94, v); chk("R8 pwr unused bits", v, 32'h4000);
        idle(15);
        chk("R7 discarded after power on", start_log.size(), 0);

        // R2 R5 R6 single conversion
        wr(8'h04, 0);
        wr(8'h04, 32'h20);
        rd(8'h10, v); chk("R5 busy", v, 1);
        wait_convs(1);
        rd(8'h10, v); chk("R5 idle", v, 0);
        chk("R2 start ch", start_log[0], 5);
        rd(dreg(5), v); chk("R6 data5", v, 32'h1000 | conv_val(5, 0));

        // R2 rewriting 1 queues nothing
        wr(8'h04, 32'h20);
        idle(15);
        chk("R2 no re-trigger", start_log.size(), 1);

        // R3 clear drops ready, keeps data
        wr(8'h04, 0);
        rd(dreg(5), v); chk("R3 ready cleared", v, conv_val(5, 0));

        // R4 ascending order
        wr(8'h04, 32'h4204);
        wait_convs(4);
        chk("R4 order 0", start_log[1], 2);
        chk("R4 order 1", start_log[2], 9);
        chk("R4 order 2", start_log[3], 14);
        rd(dreg(9), v); chk("R6 data9", v, 32'h1000 | conv_val(9, 2));

        // R3 clearing a queued request cancels it
        wr(8'h04, 0);
        wr(8'h04, 32'h0E);
        wr(8'h04, 32'h02);
        wait_convs(5);
        idle(15);
        chk("R3 cancel count", start_log.size(), 5);
        chk("R3 cancel ch", start_log[4], 1);
        rd(dreg(2), v); chk("R3 ch2 not ready", v[12], 0);

        // R7 power off drops queue, in-flight completes
        wr(8'h04, 0);
        wr(8'h04, 32'hF0);
        wr(8'h94, 0);
        wait_convs(6);
        idle(15);
        chk("R7 power-off count", start_log.size(), 6);
        rd(dreg(4), v); chk("R7 in-flight done", v, 32'h1000 | conv_val(4, 5));
        rd(dreg(6), v); chk("R7 dropped ch6", v[12], 0);
        wr(8'h94, 32'h4000);
        idle(15);
        chk("R7 no revival", start_log.size(), 6);

        // R8 unmapped, misaligned, read-only
        rd(8'h08, v); chk("R8 unmapped", v, 0);
        rd(8'h58, v); chk("R8 past data", v, 0);
        rd(8'h16, v); chk("R8 misaligned", v, 0);
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R8 stat ro", v, 0);
        wr(dreg(4), 32'hFFF);
        rd(dreg(4), v); chk("R8 data ro", v, 32'h1000 | conv_val(4, 5));

        // random passes: R2 R4 R6 R3
        for (int it = 0; it < 30; it++) begin
            logic [15:0] mask;
            int rank;
            mask = 16'($urandom);
            if (mask == 0) mask = 16'h8001;
            wr(8'h04, 0);
            base = seq_n;
            wr(8'h04, {16'h0, mask});
            wait_convs(base + $countones(mask));
            rank = 0;
            for (int ch = 0; ch < 16; ch++) begin
                rd(dreg(ch), v);
                if (mask[ch]) begin
                    chk("R4 R6 random", v, 32'h1000 | conv_val(ch, base + rank));
                    rank++;
                end else begin
                    chk("R3 random not ready", v[12], 0);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule